// File: doc/BRIEF.md
# ECC Syndrome to DIMM Locator

This block takes a corrected-error report and names the memory module and connector pin that produced the faulty bit. The report is a syndrome code and the physical address of the failing access. The requester supplies the result of the bank decode: a hit flag and the logical bank index. The block reports one of three things. For a single-bit error it returns the DIMM slot and the pin. For a multi-bit error it returns the group of four DIMMs that serve the bank. For a report it cannot place, it returns an unknown status.

The syndrome is first remapped to a bit position on the memory wire. A 64-byte line crosses the wire as four 144-bit beats, and the beat is picked by address bits [5:4]. The lookup then offsets the position by that beat. Two tables resolve the final position: a bitmap that picks one of two DIMMs per bit, and a pin table. Each table has two copies, one for symmetric and one for asymmetric population. All tables are loaded through a simple write port. A request enters on a valid/ready handshake, and the result leaves on a second valid/ready handshake after two pipeline stages.

Top module: `ecc_dimm_locator`

## Requirements
- R1: During and right after reset, rspValid is 0, rspStatus is 0 and reqReady is 1.
- R2: With rspReady held at 1, a request accepted at a rising edge produces rspValid=1 after the second following rising edge, and rspValid=0 after the first.
- R3: The two's-complement syndrome code c is remapped to r: c<128 gives c+16; 128..143 gives c-137; 144 gives 1.
- R4: The line position is p=(3-q)*144+r, where q is address bits [5:4]. The table position is t=575-p. The DIMM bit is bit (3-(t mod 4))*2 of map byte t/4.
- R5: For a single-bit error (rspStatus=0), rspPin equals pin-table entry p of the selected set.
- R6: Write port: wrTable=0 writes map byte wrAddr (0..143), wrTable=1 writes pin entry wrAddr (0..575), and wrSet picks the copy for both. wrTable=2 loads the symmetric flag from wrData[0]. The flag resets to 1. When the flag is 1, lookups use copy 0; when it is 0, they use copy 1.
- R7: Code -1 with a bank hit gives rspStatus=1 (group), rspDimm equal to the group base, and rspPin=0.
- R8: A code below -1 or above 144, or reqBankHit=0, gives rspStatus=2 (unknown), rspDimm=0 and rspPin=0.
- R9: When p falls outside 0..575 (beat 3 with codes 128..136), the response is unknown, as in R8.
- R10: While rspValid=1 and rspReady=0, the response holds stable. One more request can be taken, after which reqReady drops. No request is lost.
- R11: The group base is (reqBankIdx mod 2)*4. A single-bit rspDimm is that base plus the selected map bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reqValid | input | 1 | Error report offered |
| reqReady | output | 1 | Report can be taken this cycle |
| reqSyndrome | input | SYN_W (10) | Syndrome code, two's complement |
| reqAddr | input | ADDR_W (40) | Physical address of the failing access |
| reqBankHit | input | 1 | Address decoded to a bank |
| reqBankIdx | input | BANK_W (2) | Logical bank index |
| rspValid | output | 1 | Result available |
| rspReady | input | 1 | Result taken this cycle |
| rspStatus | output | 2 | 0 single, 1 group, 2 unknown |
| rspDimm | output | DIMM_W (3) | DIMM slot, or group base for a group result |
| rspPin | output | PIN_W (8) | Connector pin of the failing bit |
| wrEn | input | 1 | Table write strobe |
| wrTable | input | 2 | 0 map bytes, 1 pin entries, 2 symmetric flag |
| wrSet | input | 1 | Table copy written |
| wrAddr | input | 10 | Entry index |
| wrData | input | PIN_W (8) | Entry value |

## Verification
A result is due two rising edges after its request is accepted: one edge to remap and index, one edge to read the tables. The bench drives inputs and samples outputs on the falling edge. After each acceptance it checks that rspValid is still 0 at the first falling edge and that the expected result is present at the second. Under backpressure, the bench counts the edges at which the held result and reqReady must stay fixed, and checks them at each of those falling edges. Each release of rspReady is checked one edge later for the queued result and one edge after that for an empty output.

// File: rtl/ecc_loc_pkg.sv
package ecc_loc_pkg;

  typedef enum logic [1:0] {
    ST_SINGLE  = 2'd0,
    ST_GROUP   = 2'd1,
    ST_UNKNOWN = 2'd2
  } locStatus_e;

  typedef struct packed {
    logic s1Load;
    logic s2Load;
    logic tblWr;
  } locStrobe_t;

endpackage

// File: rtl/ecc_loc_ctrl.sv
module ecc_loc_ctrl
  import ecc_loc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       reqValid,
  output logic       reqReady,
  output logic       rspValid,
  input  logic       rspReady,
  input  logic       wrEn,
  output locStrobe_t strobe
);

  logic s1Valid;
  logic s2Valid;
  logic s2Free;
  logic accept;

  assign s2Free   = !s2Valid || rspReady;
  assign reqReady = !s1Valid || s2Free;
  assign accept   = reqValid && reqReady;
  assign rspValid = s2Valid;

  always_comb begin
    strobe.s1Load = accept;
    strobe.s2Load = s1Valid && s2Free;
    strobe.tblWr  = wrEn;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s1Valid <= 1'b0;
      s2Valid <= 1'b0;
    end else begin
      s1Valid <= accept || (s1Valid && !s2Free);
      s2Valid <= s2Free ? s1Valid : 1'b1;
    end
  end

endmodule

// File: rtl/ecc_loc_dp.sv
module ecc_loc_dp
  import ecc_loc_pkg::*;
#(
  parameter int SYN_W           = 10,
  parameter int QW_BITS         = 144,
  parameter int BEATS           = 4,
  parameter int PIN_W           = 8,
  parameter int NUM_BANKS       = 4,
  parameter int NUM_GROUPS      = 2,
  parameter int DIMMS_PER_GROUP = 4,
  localparam int LINE_BITS  = QW_BITS * BEATS,
  localparam int SLOTS      = 4,
  localparam int MAP_BYTES  = LINE_BITS / SLOTS,
  localparam int MAP_IDX_W  = $clog2(MAP_BYTES),
  localparam int LINE_IDX_W = $clog2(LINE_BITS),
  localparam int QW_SEL_W   = $clog2(BEATS),
  localparam int BANK_W     = $clog2(NUM_BANKS),
  localparam int DIMM_W     = $clog2(NUM_GROUPS * DIMMS_PER_GROUP)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  locStrobe_t            strobe,
  input  logic [SYN_W-1:0]      reqSyndrome,
  input  logic [QW_SEL_W-1:0]   reqQword,
  input  logic                  reqBankHit,
  input  logic [BANK_W-1:0]     reqBankIdx,
  input  logic [1:0]            wrTable,
  input  logic                  wrSet,
  input  logic [LINE_IDX_W-1:0] wrAddr,
  input  logic [PIN_W-1:0]      wrData,
  output logic [1:0]            rspStatus,
  output logic [DIMM_W-1:0]     rspDimm,
  output logic [PIN_W-1:0]      rspPin
);

  // Table copies: index 0 serves symmetric population, index 1 asymmetric.
  logic [7:0]       mapMem [2][MAP_BYTES];
  logic [PIN_W-1:0] pinMem [2][LINE_BITS];
  logic             symReg;

  // Stage 1 next-state values.
  int code, qw, remap, inLine, where;
  logic                  posOk;
  locStatus_e            statusN;
  logic [MAP_IDX_W-1:0]  byteIdxN;
  logic [2:0]            shiftN;
  logic [LINE_IDX_W-1:0] lineIdxN;
  logic [DIMM_W-1:0]     baseN;

  // Stage 1 registers.
  locStatus_e            s1Status;
  logic                  s1Set;
  logic [MAP_IDX_W-1:0]  s1ByteIdx;
  logic [2:0]            s1Shift;
  logic [LINE_IDX_W-1:0] s1LineIdx;
  logic [DIMM_W-1:0]     s1Base;

  always_comb begin
    code  = int'($signed(reqSyndrome));
    qw    = int'(reqQword);
    if (code < QW_BITS - 16)     remap = code + 16;
    else if (code < QW_BITS)     remap = code - (QW_BITS - 7);
    else if (code < QW_BITS + 3) remap = code - (QW_BITS - 1);
    else                         remap = code - (QW_BITS + 3);
    inLine = (BEATS - 1 - qw) * QW_BITS + remap;
    where  = LINE_BITS - 1 - inLine;
    posOk  = (inLine >= 0) && (inLine < LINE_BITS);

    if (!reqBankHit || code < -1 || code > QW_BITS) statusN = ST_UNKNOWN;
    else if (code == -1)                             statusN = ST_GROUP;
    else if (!posOk)                                 statusN = ST_UNKNOWN;
    else                                             statusN = ST_SINGLE;

    byteIdxN = posOk ? MAP_IDX_W'(where / SLOTS) : '0;
    shiftN   = posOk ? 3'((SLOTS - 1 - (where % SLOTS)) * 2) : 3'd0;
    lineIdxN = posOk ? LINE_IDX_W'(inLine) : '0;
    baseN    = DIMM_W'((int'(reqBankIdx) % NUM_GROUPS) * DIMMS_PER_GROUP);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s1Status  <= ST_UNKNOWN;
      s1Set     <= 1'b0;
      s1ByteIdx <= '0;
      s1Shift   <= '0;
      s1LineIdx <= '0;
      s1Base    <= '0;
    end else if (strobe.s1Load) begin
      s1Status  <= statusN;
      s1Set     <= !symReg;
      s1ByteIdx <= byteIdxN;
      s1Shift   <= shiftN;
      s1LineIdx <= lineIdxN;
      s1Base    <= baseN;
    end
  end

  // Table load port.
  always_ff @(posedge clk) begin
    if (strobe.tblWr) begin
      if (wrTable == 2'd0 && int'(wrAddr) < MAP_BYTES)
        mapMem[wrSet][wrAddr[MAP_IDX_W-1:0]] <= wrData[7:0];
      if (wrTable == 2'd1 && int'(wrAddr) < LINE_BITS)
        pinMem[wrSet][wrAddr] <= wrData;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                                  symReg <= 1'b1;
    else if (strobe.tblWr && wrTable == 2'd2) symReg <= wrData[0];
  end

  // Stage 2: table read into the response registers.
  logic [7:0]       mapByte;
  logic             mapBit;
  logic [PIN_W-1:0] pinVal;

  always_comb begin
    mapByte = mapMem[s1Set][s1ByteIdx];
    mapBit  = mapByte[s1Shift];
    pinVal  = pinMem[s1Set][s1LineIdx];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rspStatus <= ST_SINGLE;
      rspDimm   <= '0;
      rspPin    <= '0;
    end else if (strobe.s2Load) begin
      rspStatus <= s1Status;
      unique case (s1Status)
        ST_SINGLE: begin
          rspDimm <= s1Base + DIMM_W'(mapBit);
          rspPin  <= pinVal;
        end
        ST_GROUP: begin
          rspDimm <= s1Base;
          rspPin  <= '0;
        end
        default: begin
          rspDimm <= '0;
          rspPin  <= '0;
        end
      endcase
    end
  end

endmodule

// File: rtl/ecc_dimm_locator.sv
module ecc_dimm_locator
  import ecc_loc_pkg::*;
#(
  parameter int SYN_W           = 10,
  parameter int ADDR_W          = 40,
  parameter int LINE_BYTES      = 64,
  parameter int QW_BITS         = 144,
  parameter int BEATS           = 4,
  parameter int PIN_W           = 8,
  parameter int NUM_BANKS       = 4,
  parameter int NUM_GROUPS      = 2,
  parameter int DIMMS_PER_GROUP = 4,
  localparam int LINE_IDX_W = $clog2(QW_BITS * BEATS),
  localparam int QW_SEL_W   = $clog2(BEATS),
  localparam int QW_LSB     = $clog2(LINE_BYTES / BEATS),
  localparam int BANK_W     = $clog2(NUM_BANKS),
  localparam int DIMM_W     = $clog2(NUM_GROUPS * DIMMS_PER_GROUP)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  reqValid,
  output logic                  reqReady,
  input  logic [SYN_W-1:0]      reqSyndrome,
  input  logic [ADDR_W-1:0]     reqAddr,
  input  logic                  reqBankHit,
  input  logic [BANK_W-1:0]     reqBankIdx,
  output logic                  rspValid,
  input  logic                  rspReady,
  output logic [1:0]            rspStatus,
  output logic [DIMM_W-1:0]     rspDimm,
  output logic [PIN_W-1:0]      rspPin,
  input  logic                  wrEn,
  input  logic [1:0]            wrTable,
  input  logic                  wrSet,
  input  logic [LINE_IDX_W-1:0] wrAddr,
  input  logic [PIN_W-1:0]      wrData
);

  locStrobe_t          strobe;
  logic [QW_SEL_W-1:0] reqQword;
  logic                unusedAddr;

  assign reqQword   = reqAddr[QW_LSB +: QW_SEL_W];
  assign unusedAddr = ^reqAddr;

  ecc_loc_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .reqValid (reqValid),
    .reqReady (reqReady),
    .rspValid (rspValid),
    .rspReady (rspReady),
    .wrEn     (wrEn),
    .strobe   (strobe)
  );

  ecc_loc_dp #(
    .SYN_W           (SYN_W),
    .QW_BITS         (QW_BITS),
    .BEATS           (BEATS),
    .PIN_W           (PIN_W),
    .NUM_BANKS       (NUM_BANKS),
    .NUM_GROUPS      (NUM_GROUPS),
    .DIMMS_PER_GROUP (DIMMS_PER_GROUP)
  ) u_dp (
    .clk         (clk),
    .rst         (rst),
    .strobe      (strobe),
    .reqSyndrome (reqSyndrome),
    .reqQword    (reqQword),
    .reqBankHit  (reqBankHit),
    .reqBankIdx  (reqBankIdx),
    .wrTable     (wrTable),
    .wrSet       (wrSet),
    .wrAddr      (wrAddr),
    .wrData      (wrData),
    .rspStatus   (rspStatus),
    .rspDimm     (rspDimm),
    .rspPin      (rspPin)
  );

endmodule

// File: rtl/ecc_loc_chk.sv
module ecc_loc_chk
  import ecc_loc_pkg::*;
#(
  parameter int DIMM_W          = 3,
  parameter int PIN_W           = 8,
  parameter int DIMMS_PER_GROUP = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              reqValid,
  input logic              reqReady,
  input logic              rspValid,
  input logic              rspReady,
  input logic [1:0]        rspStatus,
  input logic [DIMM_W-1:0] rspDimm,
  input logic [PIN_W-1:0]  rspPin
);

  a_r1_idle_after_reset: assert property (@(posedge clk)
    rst |=> !rspValid);

  a_r2_two_cycle_result: assert property (@(posedge clk) disable iff (rst)
    (reqValid && reqReady && (!rspValid || rspReady)) |=> ##1 rspValid);

  a_r7_group_shape: assert property (@(posedge clk) disable iff (rst)
    (rspValid && rspStatus == ST_GROUP) |->
      (rspPin == '0 && (int'(rspDimm) % DIMMS_PER_GROUP) == 0));

  a_r8_unknown_zero: assert property (@(posedge clk) disable iff (rst)
    (rspValid && rspStatus == ST_UNKNOWN) |-> (rspDimm == '0 && rspPin == '0));

  a_r8_status_legal: assert property (@(posedge clk) disable iff (rst)
    rspValid |-> rspStatus != 2'd3);

  a_r10_hold_stalled: assert property (@(posedge clk) disable iff (rst)
    (rspValid && !rspReady) |=>
      (rspValid && $stable(rspStatus) && $stable(rspDimm) && $stable(rspPin)));

  a_r10_fill_then_block: assert property (@(posedge clk) disable iff (rst)
    (rspValid && !rspReady && reqValid && reqReady) |=> (!reqReady || rspReady));

endmodule

bind ecc_dimm_locator ecc_loc_chk #(
  .DIMM_W          (DIMM_W),
  .PIN_W           (PIN_W),
  .DIMMS_PER_GROUP (DIMMS_PER_GROUP)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .reqValid  (reqValid),
  .reqReady  (reqReady),
  .rspValid  (rspValid),
  .rspReady  (rspReady),
  .rspStatus (rspStatus),
  .rspDimm   (rspDimm),
  .rspPin    (rspPin)
);

// File: tb/sim_ecc_dimm_locator.sv
`timescale 1ns/1ps
module sim_ecc_dimm_locator;

  logic        clk = 1'b0;
  logic        rst;
  logic        reqValid;
  logic        reqReady;
  logic [9:0]  reqSyndrome;
  logic [39:0] reqAddr;
  logic        reqBankHit;
  logic [1:0]  reqBankIdx;
  logic        rspValid;
  logic        rspReady;
  logic [1:0]  rspStatus;
  logic [2:0]  rspDimm;
  logic [7:0]  rspPin;
  logic        wrEn;
  logic [1:0]  wrTable;
  logic        wrSet;
  logic [9:0]  wrAddr;
  logic [7:0]  wrData;

  int checks = 0;
  int failures = 0;
  bit symModel = 1'b1;

  logic [7:0] bMap [2][144];
  logic [7:0] bPin [2][576];

  always #2.5 clk = ~clk;

  ecc_dimm_locator u0 (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqReady(reqReady),
    .reqSyndrome(reqSyndrome), .reqAddr(reqAddr), .reqBankHit(reqBankHit),
    .reqBankIdx(reqBankIdx), .rspValid(rspValid), .rspReady(rspReady),
    .rspStatus(rspStatus), .rspDimm(rspDimm), .rspPin(rspPin),
    .wrEn(wrEn), .wrTable(wrTable), .wrSet(wrSet), .wrAddr(wrAddr), .wrData(wrData)
  );

  // {syndrome[9:0], quadword[1:0], bank[1:0], hit, expected status[1:0]}
  localparam logic [16:0] VEC [14] = '{
    {10'd0,   2'd0, 2'd0, 1'b1, 2'd0},   // R3 low code
    {10'd127, 2'd1, 2'd1, 1'b1, 2'd0},   // R3 top of +16 range, R11 odd bank
    {10'd128, 2'd2, 2'd2, 1'b1, 2'd0},   // R3 -137 range
    {10'd143, 2'd3, 2'd3, 1'b1, 2'd0},   // R3 end of -137 range
    {10'd144, 2'd0, 2'd0, 1'b1, 2'd0},   // R3 code 144
    {10'd50,  2'd3, 2'd1, 1'b1, 2'd0},   // R4 beat 3
    {10'd137, 2'd3, 2'd2, 1'b1, 2'd0},   // R4 line position 0
    {10'h3FF, 2'd2, 2'd1, 1'b1, 2'd1},   // R7 multi-bit, base 4
    {10'h3FF, 2'd0, 2'd2, 1'b1, 2'd1},   // R7 multi-bit, base 0
    {10'd145, 2'd0, 2'd0, 1'b1, 2'd2},   // R8 above range
    {10'h3FE, 2'd1, 2'd0, 1'b1, 2'd2},   // R8 below range
    {10'd10,  2'd1, 2'd3, 1'b0, 2'd2},   // R8 no bank hit
    {10'd130, 2'd3, 2'd0, 1'b1, 2'd2},   // R9 negative position
    {10'd136, 2'd3, 2'd1, 1'b1, 2'd2}    // R9 last negative position
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Expected {status, dimm, pin} computed from the requirements.
  function automatic logic [12:0] model(input logic [9:0] syn, input int q,
                                        input int bank, input bit hit);
    int code, r, pos, tpos, set, base, b;
    logic [7:0] mb;
    code = int'($signed(syn));
    base = (bank % 2) * 4;
    if (!hit || code < -1 || code > 144) return {2'd2, 3'd0, 8'd0};
    if (code == -1) return {2'd1, 3'(base), 8'd0};
    if (code < 128)      r = code + 16;
    else if (code < 144) r = code - 137;
    else                 r = code - 143;
    pos = (3 - q) * 144 + r;
    if (pos < 0 || pos > 575) return {2'd2, 3'd0, 8'd0};
    tpos = 575 - pos;
    set  = symModel ? 0 : 1;
    mb   = bMap[set][tpos / 4];
    b    = int'(mb[(3 - (tpos % 4)) * 2]);
    return {2'd0, 3'(base + b), bPin[set][pos]};
  endfunction

  task automatic writeTbl(input logic [1:0] tbl, input bit set, input int addr, input logic [7:0] data);
    @(negedge clk);
    wrEn = 1'b1; wrTable = tbl; wrSet = set; wrAddr = 10'(addr); wrData = data;
    @(posedge clk);
    #1 wrEn = 1'b0;
    if (tbl == 2'd0) bMap[set][addr] = data;
    if (tbl == 2'd1) bPin[set][addr] = data;
    if (tbl == 2'd2) symModel = data[0];
  endtask

  task automatic drive(input logic [9:0] syn, input int q, input int bank, input bit hit);
    reqValid = 1'b1; reqSyndrome = syn; reqBankHit = hit; reqBankIdx = 2'(bank);
    reqAddr = {8'hA5, 26'h1234, 2'(q), 4'h5};
  endtask

  task automatic lookup(input logic [9:0] syn, input int q, input int bank,
                        input bit hit, input string tag);
    logic [12:0] e;
    e = model(syn, q, bank, hit);
    @(negedge clk);
    chk(reqReady == 1'b1, {tag, " R10 ready before request"}, int'(reqReady), 1);
    drive(syn, q, bank, hit);
    @(negedge clk);
    reqValid = 1'b0;
    chk(rspValid == 1'b0, {tag, " R2 not yet valid"}, int'(rspValid), 0);
    @(negedge clk);
    chk(rspValid == 1'b1, {tag, " R2 valid after two edges"}, int'(rspValid), 1);
    chk(rspStatus == e[12:11], {tag, " R8 status"}, int'(rspStatus), int'(e[12:11]));
    chk(rspDimm == e[10:8], {tag, " R11 dimm"}, int'(rspDimm), int'(e[10:8]));
    chk(rspPin == e[7:0], {tag, " R5 pin"}, int'(rspPin), int'(e[7:0]));
  endtask

  initial begin
    #(5.0 * 150000);
    failures++;
    $display("FAIL watchdog all requirements actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [12:0] eA, eB;
    rst = 1'b1; reqValid = 1'b0; rspReady = 1'b1; wrEn = 1'b0;
    reqSyndrome = '0; reqAddr = '0; reqBankHit = 1'b0; reqBankIdx = '0;
    wrTable = '0; wrSet = 1'b0; wrAddr = '0; wrData = '0;
    repeat (3) @(negedge clk);
    chk(rspValid == 1'b0, "R1 rspValid in reset", int'(rspValid), 0);
    chk(rspStatus == 2'd0, "R1 rspStatus in reset", int'(rspStatus), 0);
    chk(reqReady == 1'b1, "R1 reqReady in reset", int'(reqReady), 1);
    rst = 1'b0;
    @(negedge clk);
    chk(rspValid == 1'b0, "R1 rspValid after reset", int'(rspValid), 0);

    // R6 load both copies of both tables
    for (int s = 0; s < 2; s++) begin
      for (int i = 0; i < 144; i++) writeTbl(2'd0, s[0], i, 8'((i * 53 + s * 170 + 29) % 256));
      for (int i = 0; i < 576; i++) writeTbl(2'd1, s[0], i, 8'((i * 13 + s * 101 + 7) % 256));
    end

    // Vector walk with the reset value of the symmetric flag (R6: copy 0)
    for (int v = 0; v < 14; v++) begin
      logic [12:0] e;
      e = model(VEC[v][16:7], int'(VEC[v][6:5]), int'(VEC[v][4:3]), VEC[v][2]);
      chk(e[12:11] == VEC[v][1:0], "R3 R4 vector status in model", int'(e[12:11]), int'(VEC[v][1:0]));
      lookup(VEC[v][16:7], int'(VEC[v][6:5]), int'(VEC[v][4:3]), VEC[v][2], "vec R3 R4");
    end

    // R6 asymmetric flag selects copy 1
    writeTbl(2'd2, 1'b0, 0, 8'd0);
    lookup(10'd0, 0, 0, 1'b1, "R6 asym a");
    lookup(10'd143, 3, 3, 1'b1, "R6 asym b");
    lookup(10'd137, 3, 2, 1'b1, "R6 asym c");

    // R6 writes to copy 1 leave symmetric lookups unchanged
    writeTbl(2'd2, 1'b0, 0, 8'd1);
    writeTbl(2'd1, 1'b1, 448, 8'hEE);
    writeTbl(2'd0, 1'b1, 31, 8'h00);
    lookup(10'd0, 0, 0, 1'b1, "R6 sym unaffected");
    chk(rspPin == bPin[0][448], "R6 pin from copy 0", int'(rspPin), int'(bPin[0][448]));

    // R10 backpressure: two requests, response held, then drained
    eA = model(10'd5, 1, 0, 1'b1);
    eB = model(10'd60, 2, 3, 1'b1);
    @(negedge clk);
    rspReady = 1'b0;
    drive(10'd5, 1, 0, 1'b1);
    @(negedge clk);
    chk(reqReady == 1'b1, "R10 second slot free", int'(reqReady), 1);
    drive(10'd60, 2, 3, 1'b1);
    @(negedge clk);
    reqValid = 1'b0;
    chk(reqReady == 1'b0, "R10 full pipe blocks", int'(reqReady), 0);
    for (int k = 0; k < 3; k++) begin
      chk(rspValid == 1'b1, "R10 held valid", int'(rspValid), 1);
      chk(rspPin == eA[7:0], "R10 held pin", int'(rspPin), int'(eA[7:0]));
      chk(rspDimm == eA[10:8], "R10 held dimm", int'(rspDimm), int'(eA[10:8]));
      @(negedge clk);
    end
    rspReady = 1'b1;
    @(negedge clk);
    chk(rspValid == 1'b1, "R10 second result valid", int'(rspValid), 1);
    chk(rspPin == eB[7:0], "R10 second pin", int'(rspPin), int'(eB[7:0]));
    chk(rspDimm == eB[10:8], "R10 R11 second dimm", int'(rspDimm), int'(eB[10:8]));
    @(negedge clk);
    chk(rspValid == 1'b0, "R10 drained", int'(rspValid), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule